// File: doc/BRIEF.md
# Satellite ranging code replica generator with early and late taps

This block produces the 1023-chip Gold ranging code of one navigation satellite as a bit stream at the sample rate. Each chip lasts a fixed number of sample clocks, twenty by default. The satellite is chosen by a 5-bit select field driven by software.

The code passes through a sample-resolution delay line. Three taps are read from it: an early replica, a prompt replica and a late replica. Early sits half a chip ahead of prompt and late sits half a chip behind it. A delay-lock loop correlates these three replicas against the received signal.

The loop controller steers the replica in two ways. Coarse steps are one whole chip: a delete request skips a chip and a duplicate request repeats one. Fine steps are one sample, set through a delay value that moves all three taps together. A one-cycle epoch pulse marks the point where the sequence returns to its first chip.

Top module: `ca_code_gen`

## Requirements
- R1: Select value v (0 to 31) picks satellite v+1, whose second-register output taps are the pair (a,b) from this list for satellites 1 to 32: (2,6) (3,7) (4,8) (5,9) (1,9) (2,10) (1,8) (2,9) (3,10) (2,3) (3,4) (5,6) (6,7) (7,8) (8,9) (9,10) (1,4) (2,5) (3,6) (4,7) (5,8) (6,9) (1,3) (4,6) (5,7) (6,8) (7,9) (8,10) (1,6) (2,7) (3,8) (4,9). Each code chip equals stage 10 of the first register XOR stages a and b of the second register. For satellite 1, the first ten chips are octal 1440, read first chip first.
- R2: The code advances by one chip every 20 sample clocks.
- R3: Both 10-stage registers start at all ones. The first register feeds back stages 3 and 10. The second register feeds back stages 2, 3, 6, 8, 9 and 10. The sequence repeats after 1023 chips.
- R4: Let n be the number of rising edges since reset release and f the effective fine delay. Then the early output carries chip floor((n-1-f)/20), the prompt output carries chip floor((n-11-f)/20), and the late output carries chip floor((n-21-f)/20). Early therefore leads prompt by 10 samples, and late trails prompt by 10 samples.
- R5: The fine delay value f (0 to 19) delays all three outputs by f samples.
- R6: A fine delay value above 19 behaves exactly as 19.
- R7: A delete request pulse is held until the next chip boundary. At that boundary the code steps two chips, so one chip is skipped.
- R8: A duplicate request pulse is held until the next chip boundary. At that boundary the code does not step, so the current chip lasts 40 samples.
- R9: If both a delete and a duplicate request are pending at the same boundary, they cancel and the code steps one chip.
- R10: The epoch output is high for one cycle when the chip index wraps past 1022. Without steering, this happens first at n = 20460.
- R11: A change of the select value reloads both registers. It also restarts the chip count and the sample phase, and it raises no epoch pulse. The edge that takes the new value acts as a reset release.
- R12: While reset is asserted, and in the cycle after release, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (20 samples per chip) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sat_sel | input | 5 | Satellite select, value v picks satellite v+1 |
| del_req | input | 1 | Request to skip one chip at the next chip boundary |
| dup_req | input | 1 | Request to repeat the current chip at the next boundary |
| fine_dly | input | 5 | Sub-chip delay in samples, clamped to 19 |
| code_early | output | 1 | Replica half a chip ahead of prompt |
| code_prompt | output | 1 | Prompt replica |
| code_late | output | 1 | Replica half a chip behind prompt |
| epoch | output | 1 | One-cycle pulse at the start of each code period |

## Verification
The bench builds the block with its default values: 20 samples per chip and 20 fine-delay stages. The full 1023-chip period and its epoch pulse then fit in about twenty thousand cycles, so the wrap and the restart after a satellite change are both observed directly. Because the 5-bit delay field can carry values up to 31, the clamp above 19 can be reached. Half a chip of ten samples also leaves sample points where early differs from prompt and points where prompt differs from late.

// File: rtl/ca_code_pkg.sv
package ca_code_pkg;

  localparam int LFSR_LEN = 10;
  localparam int CODE_LEN = (1 << LFSR_LEN) - 1;

  typedef logic [LFSR_LEN:1] lfsr_t;

  typedef struct packed {
    logic [3:0] a;
    logic [3:0] b;
  } g2_pick_t;

  // Second-register output stage pair for each satellite (select value = number - 1)
  function automatic g2_pick_t g2_pick(input logic [4:0] sel);
    g2_pick_t r;
    case (sel)
      5'd0:  r = {4'd2, 4'd6};
      5'd1:  r = {4'd3, 4'd7};
      5'd2:  r = {4'd4, 4'd8};
      5'd3:  r = {4'd5, 4'd9};
      5'd4:  r = {4'd1, 4'd9};
      5'd5:  r = {4'd2, 4'd10};
      5'd6:  r = {4'd1, 4'd8};
      5'd7:  r = {4'd2, 4'd9};
      5'd8:  r = {4'd3, 4'd10};
      5'd9:  r = {4'd2, 4'd3};
      5'd10: r = {4'd3, 4'd4};
      5'd11: r = {4'd5, 4'd6};
      5'd12: r = {4'd6, 4'd7};
      5'd13: r = {4'd7, 4'd8};
      5'd14: r = {4'd8, 4'd9};
      5'd15: r = {4'd9, 4'd10};
      5'd16: r = {4'd1, 4'd4};
      5'd17: r = {4'd2, 4'd5};
      5'd18: r = {4'd3, 4'd6};
      5'd19: r = {4'd4, 4'd7};
      5'd20: r = {4'd5, 4'd8};
      5'd21: r = {4'd6, 4'd9};
      5'd22: r = {4'd1, 4'd3};
      5'd23: r = {4'd4, 4'd6};
      5'd24: r = {4'd5, 4'd7};
      5'd25: r = {4'd6, 4'd8};
      5'd26: r = {4'd7, 4'd9};
      5'd27: r = {4'd8, 4'd10};
      5'd28: r = {4'd1, 4'd6};
      5'd29: r = {4'd2, 4'd7};
      5'd30: r = {4'd3, 4'd8};
      default: r = {4'd4, 4'd9};
    endcase
    return r;
  endfunction

  // First register: feedback from stages 3 and 10, new bit enters stage 1
  function automatic lfsr_t g1_advance(input lfsr_t s);
    return {s[LFSR_LEN-1:1], s[3] ^ s[10]};
  endfunction

  // Second register: feedback from stages 2,3,6,8,9,10
  function automatic lfsr_t g2_advance(input lfsr_t s);
    return {s[LFSR_LEN-1:1], s[2] ^ s[3] ^ s[6] ^ s[8] ^ s[9] ^ s[10]};
  endfunction

  function automatic logic gold_bit(input lfsr_t g1, input lfsr_t g2, input g2_pick_t p);
    return g1[LFSR_LEN] ^ g2[p.a] ^ g2[p.b];
  endfunction

endpackage

// File: rtl/ca_chip_timer.sv
module ca_chip_timer #(
  parameter int SAMPLES_PER_CHIP = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  output logic chip_stb
);

  localparam int CW = (SAMPLES_PER_CHIP > 1) ? $clog2(SAMPLES_PER_CHIP) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLES_PER_CHIP - 1);

  logic [CW-1:0] phase;

  assign chip_stb = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  phase <= '0;
    else if (reload || chip_stb) phase <= '0;
    else                         phase <= phase + 1'b1;
  end

  // R2: sample phase never leaves its range
  a_r2_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST);

  generate
    if (SAMPLES_PER_CHIP > 1) begin : g_stb_chk
      // R2: a chip boundary is never followed directly by another
      a_r2_strobe_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        chip_stb |=> !chip_stb);
    end
  endgenerate

endmodule

// File: rtl/ca_gold_core.sv
module ca_gold_core
  import ca_code_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     chip_stb,
  input  logic     reload,
  input  logic     del_req,
  input  logic     dup_req,
  input  g2_pick_t pick,
  output logic     chip_bit,
  output logic     epoch
);

  localparam lfsr_t ONES = '1;
  localparam int SW = LFSR_LEN + 1;

  lfsr_t g1, g2;
  lfsr_t g1_one, g1_two, g2_one, g2_two;
  logic [LFSR_LEN-1:0] idx;
  logic [SW-1:0] idx_sum;
  logic pend_del, pend_dup, epoch_q;
  logic [1:0] step;
  logic wrap;

  assign g1_one = g1_advance(g1);
  assign g1_two = g1_advance(g1_one);
  assign g2_one = g2_advance(g2);
  assign g2_two = g2_advance(g2_one);

  // Chip step taken at the coming boundary: skip, hold, or normal
  always_comb begin
    if (pend_del && !pend_dup)      step = 2'd2;
    else if (pend_dup && !pend_del) step = 2'd0;
    else                            step = 2'd1;
  end

  assign idx_sum = {1'b0, idx} + SW'(step);
  assign wrap    = idx_sum >= SW'(CODE_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g1 <= ONES;
      g2 <= ONES;
      idx <= '0;
      pend_del <= 1'b0;
      pend_dup <= 1'b0;
      epoch_q <= 1'b0;
    end else if (reload) begin
      g1 <= ONES;
      g2 <= ONES;
      idx <= '0;
      pend_del <= 1'b0;
      pend_dup <= 1'b0;
      epoch_q <= 1'b0;
    end else if (chip_stb) begin
      case (step)
        2'd0:    begin g1 <= g1;     g2 <= g2;     end
        2'd2:    begin g1 <= g1_two; g2 <= g2_two; end
        default: begin g1 <= g1_one; g2 <= g2_one; end
      endcase
      idx <= LFSR_LEN'(wrap ? idx_sum - SW'(CODE_LEN) : idx_sum);
      pend_del <= del_req;
      pend_dup <= dup_req;
      epoch_q <= wrap;
    end else begin
      pend_del <= pend_del | del_req;
      pend_dup <= pend_dup | dup_req;
      epoch_q <= 1'b0;
    end
  end

  assign chip_bit = gold_bit(g1, g2, pick);
  assign epoch    = epoch_q;

  // R3: chip index stays inside one code period
  a_r3_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx < LFSR_LEN'(CODE_LEN));

  // R3: both registers are back at all ones whenever the index is at chip 0
  a_r3_home_state: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == '0) |-> (g1 == ONES && g2 == ONES));

  // R10: epoch only appears right after a wrap
  a_r10_epoch_index: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_q |-> (idx < LFSR_LEN'(2)));

  // R11: a reload restarts the count with no epoch
  a_r11_reload_home: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (idx == '0 && !epoch_q));

  // R8: a lone duplicate holds the code state across the boundary
  a_r8_dup_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_stb && pend_dup && !pend_del && !reload) |=> (idx == $past(idx) && g1 == $past(g1)));

endmodule

// File: rtl/ca_tap_line.sv
module ca_tap_line #(
  parameter int FINE_STAGES = 20,
  parameter int HALF        = 10,
  parameter int FW          = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [FW-1:0] fine,
  output logic          early,
  output logic          prompt,
  output logic          late
);

  localparam int DEPTH = FINE_STAGES + 2 * HALF;
  localparam int IW    = $clog2(DEPTH);

  logic [DEPTH-1:0] sr;
  logic [FW-1:0]    fine_eff;
  logic [IW-1:0]    base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[DEPTH-2:0], din};
  end

  // Clamp only when the field can encode more stages than exist
  generate
    if ((1 << FW) > FINE_STAGES) begin : g_clamp
      assign fine_eff = (fine > FW'(FINE_STAGES - 1)) ? FW'(FINE_STAGES - 1) : fine;
    end else begin : g_direct
      assign fine_eff = fine;
    end
  endgenerate

  assign base   = IW'(fine_eff);
  assign early  = sr[base];
  assign prompt = sr[base + IW'(HALF)];
  assign late   = sr[base + IW'(2 * HALF)];

endmodule

// File: rtl/ca_code_gen.sv
module ca_code_gen
  import ca_code_pkg::*;
#(
  parameter int SAMPLES_PER_CHIP = 20,
  parameter int FINE_STAGES      = 20,
  localparam int FINE_W          = $clog2(FINE_STAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        sat_sel,
  input  logic              del_req,
  input  logic              dup_req,
  input  logic [FINE_W-1:0] fine_dly,
  output logic              code_early,
  output logic              code_prompt,
  output logic              code_late,
  output logic              epoch
);

  localparam int HALF = SAMPLES_PER_CHIP / 2;

  logic [4:0] sat_q;
  logic       reload;
  logic       chip_stb;
  logic       chip_bit;
  g2_pick_t   pick;

  // Tracks the select every clock, also during reset, so release needs no reload
  always_ff @(posedge clk) sat_q <= sat_sel;

  assign reload = (sat_sel != sat_q);
  assign pick   = g2_pick(sat_sel);

  ca_chip_timer #(.SAMPLES_PER_CHIP(SAMPLES_PER_CHIP)) u_timer (
    .clk(clk), .rst_n(rst_n), .reload(reload), .chip_stb(chip_stb)
  );

  ca_gold_core u_core (
    .clk(clk), .rst_n(rst_n), .chip_stb(chip_stb), .reload(reload),
    .del_req(del_req), .dup_req(dup_req), .pick(pick),
    .chip_bit(chip_bit), .epoch(epoch)
  );

  ca_tap_line #(.FINE_STAGES(FINE_STAGES), .HALF(HALF), .FW(FINE_W)) u_taps (
    .clk(clk), .rst_n(rst_n), .din(chip_bit), .fine(fine_dly),
    .early(code_early), .prompt(code_prompt), .late(code_late)
  );

  // R10: epoch is a single-cycle pulse
  a_r10_epoch_single: assert property (@(posedge clk) disable iff (!rst_n)
    epoch |=> !epoch);

endmodule

// File: tb/tb_ca_code_gen.sv
module tb_ca_code_gen;

  localparam int CLK_PERIOD = 10;
  localparam int SPC  = 20;
  localparam int HLF  = 10;

  // {select, first ten chips in octal}
  localparam logic [14:0] VEC [10] = '{
    {5'd0, 10'o1440}, {5'd1, 10'o1620}, {5'd2, 10'o1710}, {5'd3, 10'o1744},
    {5'd4, 10'o1133}, {5'd5, 10'o1455}, {5'd6, 10'o1131}, {5'd7, 10'o1454},
    {5'd8, 10'o1626}, {5'd9, 10'o1504}
  };

  localparam int TAP_A [32] = '{2,3,4,5,1,2,1,2,3,2,3,5,6,7,8,9,1,2,3,4,5,6,1,4,5,6,7,8,1,2,3,4};
  localparam int TAP_B [32] = '{6,7,8,9,9,10,8,9,10,3,4,6,7,8,9,10,4,5,6,7,8,9,3,6,7,8,9,10,6,7,8,9};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] sat_sel = '0;
  logic del_req = 1'b0;
  logic dup_req = 1'b0;
  logic [4:0] fine_dly = '0;
  logic code_early, code_prompt, code_late, epoch;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  ca_code_gen dut (
    .clk(clk), .rst_n(rst_n), .sat_sel(sat_sel), .del_req(del_req), .dup_req(dup_req),
    .fine_dly(fine_dly), .code_early(code_early), .code_prompt(code_prompt),
    .code_late(code_late), .epoch(epoch)
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  function automatic bit model_chip(input int prn, input int idx);
    bit [1:10] a, b;
    bit fa, fb;
    a = '1;
    b = '1;
    for (int i = 0; i < (idx % 1023); i++) begin
      fa = a[3] ^ a[10];
      fb = b[2] ^ b[3] ^ b[6] ^ b[8] ^ b[9] ^ b[10];
      a = {fa, a[1:9]};
      b = {fb, b[1:9]};
    end
    return a[10] ^ b[TAP_A[prn-1]] ^ b[TAP_B[prn-1]];
  endfunction

  // mode 0 plain, 1 one chip deleted at first boundary, 2 one chip duplicated there
  function automatic bit exp_tap(input int prn, input int m, input int d, input int mode);
    int pos, p, ci;
    pos = m - 1 - d;
    if (pos < 0) return 1'b0;
    p = pos / SPC;
    case (mode)
      1:       ci = (p == 0) ? 0 : p + 1;
      2:       ci = (p <= 1) ? 0 : p - 1;
      default: ci = p;
    endcase
    return model_chip(prn, ci);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic go_to(input int m);
    while (cyc < m) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic apply_reset(input logic [4:0] sel, input logic [4:0] f);
    @(negedge clk);
    rst_n = 1'b0;
    sat_sel = sel;
    fine_dly = f;
    del_req = 1'b0;
    dup_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
  endtask

  task automatic chk_triple(input string req, input int prn, input int m, input int f, input int mode);
    logic [2:0] e;
    go_to(m);
    e = {exp_tap(prn, m, f, mode), exp_tap(prn, m, f + HLF, mode), exp_tap(prn, m, f + 2 * HLF, mode)};
    chk(req, {29'd0, code_early, code_prompt, code_late}, {29'd0, e});
  endtask

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      report();
      $finish;
    end
  end

  initial begin
    logic [9:0] w;
    int base;

    // R12: outputs quiet in reset and in the cycle after release
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 in reset", {28'd0, code_early, code_prompt, code_late, epoch}, 32'd0);
    apply_reset(5'd0, 5'd0);
    chk("R12 after release", {28'd0, code_early, code_prompt, code_late, epoch}, 32'd0);

    // R1, R2, R3: first ten chips of ten satellites against the table
    for (int v = 0; v < 10; v++) begin
      apply_reset(VEC[v][14:10], 5'd0);
      w = '0;
      for (int k = 0; k < 10; k++) begin
        go_to(SPC * k + 16);
        w = {w[8:0], code_prompt};
      end
      chk($sformatf("R1 satellite %0d first chips", v + 1), {22'd0, w}, {22'd0, VEC[v][9:0]});
    end

    // R4, R1: three taps of satellite 32, inside and across chip halves
    apply_reset(5'd31, 5'd0);
    for (int k = 1; k < 12; k++) begin
      chk_triple("R4 taps mid-chip", 32, SPC * k + 8, 0, 0);
      chk_triple("R4 taps late-chip", 32, SPC * k + 16, 0, 0);
    end

    // R5: full fine delay shifts all taps by 19 samples
    apply_reset(5'd0, 5'd19);
    for (int k = 1; k < 8; k++) begin
      chk_triple("R5 fine 19", 1, SPC * k + 16, 19, 0);
      chk_triple("R5 fine 19 shifted", 1, SPC * k + 35, 19, 0);
    end

    // R6: out-of-range fine value acts as 19
    apply_reset(5'd0, 5'd31);
    for (int k = 1; k < 8; k++) begin
      chk_triple("R6 fine clamp", 1, SPC * k + 16, 19, 0);
      chk_triple("R6 fine clamp shifted", 1, SPC * k + 35, 19, 0);
    end

    // R7: delete request skips chip 1
    apply_reset(5'd0, 5'd0);
    go_to(2); del_req = 1'b1;
    go_to(3); del_req = 1'b0;
    for (int k = 1; k < 6; k++) chk_triple("R7 delete", 1, SPC * k + 16, 0, 1);

    // R8: duplicate request repeats chip 0
    apply_reset(5'd0, 5'd0);
    go_to(2); dup_req = 1'b1;
    go_to(3); dup_req = 1'b0;
    for (int k = 1; k < 6; k++) chk_triple("R8 duplicate", 1, SPC * k + 16, 0, 2);

    // R9: both pending together leave the code on its plain course
    apply_reset(5'd0, 5'd0);
    go_to(2); del_req = 1'b1;
    go_to(3); del_req = 1'b0;
    go_to(5); dup_req = 1'b1;
    go_to(6); dup_req = 1'b0;
    for (int k = 1; k < 6; k++) chk_triple("R9 cancel", 1, SPC * k + 16, 0, 0);

    // R10, R3: epoch at the period wrap and code repeats
    apply_reset(5'd0, 5'd0);
    go_to(20459); chk("R10 epoch before wrap", {31'd0, epoch}, 32'd0);
    go_to(20460); chk("R10 epoch at wrap", {31'd0, epoch}, 32'd1);
    go_to(20461); chk("R10 epoch one cycle", {31'd0, epoch}, 32'd0);
    for (int k = 1023; k < 1028; k++) begin
      go_to(SPC * k + 16);
      chk("R3 period 1023", {31'd0, code_prompt}, {31'd0, model_chip(1, k - 1023)});
    end

    // R11: select change reloads and restarts the period
    go_to(cyc + 7);
    sat_sel = 5'd4;
    base = cyc + 1;
    go_to(base);
    chk("R11 no epoch on reload", {31'd0, epoch}, 32'd0);
    w = '0;
    for (int k = 0; k < 10; k++) begin
      go_to(base + SPC * k + 16);
      w = {w[8:0], code_prompt};
    end
    chk("R11 new satellite from chip 0", {22'd0, w}, {22'd0, 10'o1133});
    go_to(base + 20459); chk("R11 epoch not early", {31'd0, epoch}, 32'd0);
    go_to(base + 20460); chk("R11 epoch after restart", {31'd0, epoch}, 32'd1);

    done = 1;
    report();
    $finish;
  end

endmodule